// File: doc/BRIEF.md
# Serial Channel with Diagnostic Loopback

This block is one asynchronous serial channel. It has a transmit shifter with a one-byte holding register, a mid-bit sampling receiver and a modem control register. A small register bus with a 3-bit offset reaches all of them. Frames are 8N1. Bit timing comes from an external baud tick input, and sixteen ticks make one bit.

Setting the loopback bit in the modem control register routes the transmitter's serial stream straight into the receiver inside the block. Software can then send a byte and read it back without touching the line. While loopback is active, the line output stays at mark, both modem control outputs are inactive, and the four modem status inputs are cut off from the status register.

Top module: `uart_loop_chan`

## Requirements
- R1: The modem control register is written and read at offset 4, and bits 4:0 read back as written. Bit 4 set selects loopback and bit 4 clear selects normal operation.
- R2: In loopback the receiver takes the transmitter's serial output, and the rx_i pin has no effect on received data.
- R3: In loopback tx_o stays at 1 (mark), even while a frame is being shifted out.
- R4: Outside loopback, dtr_no equals the inverse of control bit 0 and rts_no equals the inverse of control bit 1. In loopback both outputs are 1.
- R5: Offset 6 returns the inverted cts_ni in bit 4, the inverted dsr_ni in bit 5, the inverted ri_ni in bit 6 and the inverted cd_ni in bit 7, with bits 3:0 at 0. In loopback all of bits 7:4 read 0.
- R6: Outside loopback, a byte written to offset 0 appears on tx_o as one low start bit, eight data bits LSB first and one high stop bit, each lasting 16 baud ticks. tx_o is 1 when idle.
- R7: The receiver samples each bit at its middle. A start bit that is high again at its midpoint is dropped and yields no byte.
- R8: Offset 5 bit 0 is set when a byte is received and cleared by a read of offset 0. Offset 5 bit 5 is 1 only while both the holding register and the shifter are empty. After reset, offset 5 reads 0x20.
- R9: A byte written to offset 0 in loopback is later read back unchanged from offset 0.
- R10: A byte written while a frame is still being sent is kept and transmitted directly after that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe; side effects only |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| tx_o | output | 1 | Serial line output |
| rx_i | input | 1 | Serial line input |
| rts_no | output | 1 | Request-to-send, active low |
| dtr_no | output | 1 | Terminal-ready, active low |
| cts_ni | input | 1 | Clear-to-send, active low |
| dsr_ni | input | 1 | Set-ready, active low |
| cd_ni | input | 1 | Carrier detect, active low |
| ri_ni | input | 1 | Ring indicator, active low |

## Verification
The hardest state to reach from the ports is loopback with hostile pins. The bench must show that a held-low rx_i and fully asserted modem inputs leave no trace, even while a frame is moving through the internal path. To get there, it sets loopback together with both modem control bits, forces rx_i low and drives every status input active, then sends random bytes. Across each whole frame it watches tx_o, rts_no and dtr_no, and it compares every byte read back. A glitch on rx_i that is too short to be a start bit is also driven on purpose, to show that the midpoint check rejects it.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;
  localparam int DATA_W = 8;
  localparam int OVS    = 16;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTA = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTA = 3'd6;
  localparam int LOOP_BIT  = 4;
  localparam int MCTL_W    = 5;
endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ser_o,
  output logic              empty_o
);
  localparam int FRAME = DATA_W + 2;
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FRAME);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q;
  logic              busy_q;
  logic [FRAME-1:0]  sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      sh_q        <= '1;
      cnt_q       <= '0;
      bit_q       <= '0;
    end else begin
      if (!busy_q && hold_full_q) begin
        sh_q        <= {1'b1, hold_q, 1'b0};
        busy_q      <= 1'b1;
        cnt_q       <= '0;
        bit_q       <= '0;
        hold_full_q <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (cnt_q == CNT_W'(OVS-1)) begin
          cnt_q <= '0;
          sh_q  <= {1'b1, sh_q[FRAME-1:1]};
          if (bit_q == BIT_W'(FRAME-1)) busy_q <= 1'b0;
          else                          bit_q  <= bit_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      // a load in the same cycle as a start refills the holder
      if (load_i) begin
        hold_q      <= data_i;
        hold_full_q <= 1'b1;
      end
    end
  end

  assign ser_o   = busy_q ? sh_q[0] : 1'b1;
  assign empty_o = !busy_q && !hold_full_q;
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ser_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              done_o
);
  localparam int FRAME = DATA_W + 2;
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FRAME);
  localparam int MID   = OVS/2 - 1;

  logic              act_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (!act_q) begin
          if (!ser_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
            bit_q <= '0;
          end
        end else begin
          if (cnt_q == CNT_W'(OVS-1)) begin
            cnt_q <= '0;
            bit_q <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          if (cnt_q == CNT_W'(MID)) begin
            if (bit_q == '0) begin
              if (ser_i) act_q <= 1'b0;  // glitch, not a start bit
            end else if (bit_q == BIT_W'(FRAME-1)) begin
              act_q <= 1'b0;
              if (ser_i) begin
                data_o <= sh_q;
                done_o <= 1'b1;
              end
            end else begin
              sh_q <= {ser_i, sh_q[DATA_W-1:1]};
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ready_o <= 1'b0;
    else if (done_o) ready_o <= 1'b1;
    else if (clr_i)  ready_o <= 1'b0;
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl #(
  parameter int MCTL_W   = 5,
  parameter int LOOP_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MCTL_W-1:0] wdata_i,
  input  logic              tx_ser_i,
  input  logic              rx_pin_i,
  input  logic              cts_ni,
  input  logic              dsr_ni,
  input  logic              cd_ni,
  input  logic              ri_ni,
  output logic [MCTL_W-1:0] mctl_o,
  output logic              loop_o,
  output logic              tx_o,
  output logic              rx_ser_o,
  output logic              rts_no,
  output logic              dtr_no,
  output logic [7:0]        msta_o
);
  logic [1:0] rx_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mctl_o <= '0;
    else if (we_i) mctl_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_sync_q <= 2'b11;
    else         rx_sync_q <= {rx_sync_q[0], rx_pin_i};
  end

  assign loop_o   = mctl_o[LOOP_BIT];
  assign tx_o     = loop_o ? 1'b1 : tx_ser_i;
  assign rx_ser_o = loop_o ? tx_ser_i : rx_sync_q[1];
  assign dtr_no   = loop_o ? 1'b1 : ~mctl_o[0];
  assign rts_no   = loop_o ? 1'b1 : ~mctl_o[1];
  assign msta_o   = loop_o ? 8'h00 : {~cd_ni, ~ri_ni, ~dsr_ni, ~cts_ni, 4'h0};
endmodule

// File: rtl/uart_loop_chan.sv
module uart_loop_chan
  import uart_loop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              rts_no,
  output logic              dtr_no,
  input  logic              cts_ni,
  input  logic              dsr_ni,
  input  logic              cd_ni,
  input  logic              ri_ni
);
  logic              tx_ser, tx_empty, rx_ser, rx_ready, rx_done, loop_en;
  logic [DATA_W-1:0] rx_data;
  logic [MCTL_W-1:0] mctl;
  logic [7:0]        msta;

  uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i(baud_tick_i),
    .load_i(we_i && addr_i == OFS_DATA), .data_i(wdata_i),
    .ser_o(tx_ser), .empty_o(tx_empty)
  );

  uart_rx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .tick_i(baud_tick_i), .ser_i(rx_ser),
    .clr_i(re_i && addr_i == OFS_DATA),
    .data_o(rx_data), .ready_o(rx_ready), .done_o(rx_done)
  );

  uart_modem_ctl #(.MCTL_W(MCTL_W), .LOOP_BIT(LOOP_BIT)) u_mdm (
    .clk_i, .rst_ni, .we_i(we_i && addr_i == OFS_MCTL),
    .wdata_i(wdata_i[MCTL_W-1:0]), .tx_ser_i(tx_ser), .rx_pin_i(rx_i),
    .cts_ni, .dsr_ni, .cd_ni, .ri_ni,
    .mctl_o(mctl), .loop_o(loop_en), .tx_o, .rx_ser_o(rx_ser),
    .rts_no, .dtr_no, .msta_o(msta)
  );

  always_comb begin
    case (addr_i)
      OFS_DATA: rdata_o = rx_data;
      OFS_MCTL: rdata_o = DATA_W'(mctl);
      OFS_LSTA: rdata_o = {2'b00, tx_empty, 4'h0, rx_ready};
      OFS_MSTA: rdata_o = msta;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_loop_chan_chk.sv
module uart_loop_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       re_i,
  input logic [2:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       tx_o,
  input logic       rts_no,
  input logic       dtr_no,
  input logic       loop_en,
  input logic       rx_ready,
  input logic       rx_done,
  input logic       tx_empty
);
  AST_LOOP_TX_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en |-> tx_o); // R3
  AST_LOOP_MODEM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en |-> (rts_no && dtr_no)); // R4
  AST_LOOP_MSTA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_en && addr_i == 3'd6) |-> rdata_o[7:4] == 4'h0); // R5
  AST_READ_CLEARS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 3'd0 && !rx_done) |=> !rx_ready); // R8
  AST_DONE_SETS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |=> rx_ready); // R8
  AST_IDLE_LINE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_en && tx_empty) |-> tx_o); // R6
endmodule

bind uart_loop_chan uart_loop_chan_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .re_i(re_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .tx_o(tx_o), .rts_no(rts_no), .dtr_no(dtr_no),
  .loop_en(loop_en), .rx_ready(rx_ready), .rx_done(rx_done),
  .tx_empty(tx_empty)
);

// File: tb/uart_loop_chan_test.sv
`timescale 1ns/1ps
module uart_loop_chan_test;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       we = 1'b0, re = 1'b0, rx = 1'b1;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic       tx, rts_n, dtr_n;
  logic       cts_n = 1'b1, dsr_n = 1'b1, cd_n = 1'b1, ri_n = 1'b1;
  int         n_chk = 0, n_err = 0;
  bit         tx_went_low, modem_went_low;

  always #10 clk = ~clk;

  uart_loop_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tx_o(tx), .rx_i(rx),
    .rts_no(rts_n), .dtr_no(dtr_n), .cts_ni(cts_n), .dsr_ni(dsr_n),
    .cd_ni(cd_n), .ri_ni(ri_n)
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c == 3) ? 0 : c + 1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_msta(input logic lp, input logic c, input logic d,
                                          input logic r, input logic k);
    return lp ? 8'h00 : {~k, ~r, ~d, ~c, 4'h0};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #2 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic capture_tx(output logic [7:0] b, output logic st, output logic sp);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!tx) break;
    end
    wait_ticks(8); #5 st = tx;
    for (int i = 0; i < 8; i++) begin
      wait_ticks(16); #5 b[i] = tx;
    end
    wait_ticks(16); #5 sp = tx;
  endtask

  task automatic send_rx(input logic [7:0] b);
    wait_ticks(1); #5 rx = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      #5 rx = b[i];
      wait_ticks(16);
    end
    #5 rx = 1'b1;
    wait_ticks(16);
  endtask

  task automatic wait_ready(output logic ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd5, s);
      if (tx !== 1'b1) tx_went_low = 1'b1;
      if (rts_n !== 1'b1 || dtr_n !== 1'b1) modem_went_low = 1'b1;
      if (s[0]) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v, b, b2;
    logic st, sp, ok;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(3'd5, v); chk("R8 reset line status", v, 8'h20);
    rd(3'd4, v); chk("R1 reset control", v, 8'h00);
    chk("R6 idle tx", {7'd0, tx}, 8'h01);
    chk("R4 reset dtr/rts", {6'd0, rts_n, dtr_n}, 8'h03);
    rd(3'd6, v); chk("R5 inactive inputs", v, 8'h00);

    // normal modem control
    wr(3'd4, 8'h01); #2 chk("R4 dtr only", {6'd0, rts_n, dtr_n}, 8'h02);
    wr(3'd4, 8'h03); #2 chk("R4 dtr and rts", {6'd0, rts_n, dtr_n}, 8'h00);
    rd(3'd4, v); chk("R1 control readback", v, 8'h03);

    // modem status, random inputs
    for (int i = 0; i < 4; i++) begin
      {cts_n, dsr_n, ri_n, cd_n} = 4'($urandom());
      rd(3'd6, v); chk("R5 status bits", v, exp_msta(1'b0, cts_n, dsr_n, ri_n, cd_n));
    end
    {cts_n, dsr_n, ri_n, cd_n} = 4'hF;

    // transmit frame
    b = 8'($urandom());
    wr(3'd0, b);
    rd(3'd5, v); chk("R8 not empty while sending", v & 8'h20, 8'h00);
    capture_tx(v, st, sp);
    chk("R6 start bit", {7'd0, st}, 8'h00);
    chk("R6 data LSB first", v, b);
    chk("R6 stop bit", {7'd0, sp}, 8'h01);
    wait_ticks(16);
    rd(3'd5, v); chk("R8 empty after frame", v & 8'h20, 8'h20);

    // back-to-back bytes, second held while first is on the line
    b = 8'h80; b2 = 8'h01;
    wr(3'd0, b);
    repeat (10) @(negedge clk);
    wr(3'd0, b2);
    capture_tx(v, st, sp); chk("R10 first byte", v, b);
    capture_tx(v, st, sp); chk("R10 held byte", v, b2);
    chk("R10 held byte stop", {7'd0, sp}, 8'h01);

    // receive from pin
    for (int i = 0; i < 3; i++) begin
      b = (i == 0) ? 8'h55 : 8'($urandom());
      send_rx(b);
      wait_ready(ok);
      chk("R7 byte received", {7'd0, ok}, 8'h01);
      rd(3'd0, v); chk("R7 received value", v, b);
      rd(3'd5, v); chk("R8 ready cleared by read", v & 8'h01, 8'h00);
    end

    // short glitch must not start a frame
    wait_ticks(1); #5 rx = 1'b0;
    wait_ticks(4); #5 rx = 1'b1;
    wait_ticks(200);
    rd(3'd5, v); chk("R7 glitch rejected", v & 8'h01, 8'h00);

    // loopback with hostile pins
    wr(3'd4, 8'h13);
    rd(3'd4, v); chk("R1 loop control readback", v, 8'h13);
    #2 chk("R4 outputs inactive in loop", {6'd0, rts_n, dtr_n}, 8'h03);
    rx = 1'b0;
    {cts_n, dsr_n, ri_n, cd_n} = 4'h0;
    rd(3'd6, v); chk("R5 status zero in loop", v, 8'h00);
    tx_went_low = 1'b0; modem_went_low = 1'b0;
    for (int i = 0; i < 5; i++) begin
      b = (i == 0) ? 8'h00 : 8'($urandom());
      wr(3'd0, b);
      wait_ready(ok);
      chk("R9 loop byte arrived", {7'd0, ok}, 8'h01);
      rd(3'd0, v); chk("R2 R9 loop byte value", v, b);
    end
    chk("R3 tx held at mark", {7'd0, tx_went_low}, 8'h00);
    chk("R4 modem outputs held inactive", {7'd0, modem_went_low}, 8'h00);
    rd(3'd6, v); chk("R5 status still zero", v, 8'h00);

    // leave loopback
    rx = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd4, 8'h00);
    rd(3'd6, v); chk("R5 status after loop exit", v, 8'hF0);
    #2 chk("R1 R4 normal after exit", {6'd0, rts_n, dtr_n}, 8'h03);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule